// File: doc/BRIEF.md
# FM/MFM Address Mark Serializer

This block sits on the write path of a floppy disk controller. It takes one parallel byte per byte slot and turns it into a stream of encoded bit cells, one cell per clock. The stream goes out on a single write-data line. Each byte becomes sixteen cells. Each data bit has a clock cell in front of it, and the cells go out most significant bit first. Single density (FM) and double density (MFM) encoding are both supported. The mode is chosen per byte.

When the mark-enable input is set, some byte values are written with a changed clock pattern so that a reader cannot mistake them for ordinary data:

- In FM the block substitutes a reduced clock byte.
- In MFM it removes one clock transition at a fixed position.

A byte-taken pulse marks the cell slot in which a following byte is accepted. Bytes therefore stream with no gap between them. CRC, index timing and data-register handling are left to the surrounding logic.

Top module: `amSerializer`

## Requirements
- R1: Reset clears the line and the stored bit. While reset is asserted, and after it until a byte is accepted, `wrData` and `byteTaken` are 0. The remembered previous data bit is cleared to 0.
- R2: FM, plain bytes. A byte is sent as 16 cells over 16 consecutive clocks, most significant bit first. Each data bit is preceded by its clock cell. In FM, non-mark bytes use an all-ones clock byte, so data 0x00 gives the cell word 0xAAAA.
- R3: FM marks F8 to FB and FE. With `markEn`=1 in FM, bytes 0xF8 to 0xFB and 0xFE use clock byte 0xC7. Clock bit 7 is paired with data bit 7, and so on down. For example, 0xFE gives 0xF57E and 0xF8 gives 0xF56A.
- R4: FM mark FC. With `markEn`=1 in FM, byte 0xFC uses clock byte 0xD7, giving 0xF77A.
- R5: MFM clock rule. In MFM a clock cell is 1 only when the data bit before it and the data bit after it are both 0. For bit 7 the previous bit is bit 0 of the last byte sent, in any mode. That bit is kept across idle gaps, so MFM 0x00 after a byte ending in 1 gives 0x2AAA. MFM never places two 1 cells back to back.
- R6: MFM mark A1. With `markEn`=1 in MFM, byte 0xA1 has the clock cell in front of data bit 2 forced to 0 (bit 0 is the least significant). This gives 0x4489, where 0x44A9 would be the plain encoding.
- R7: MFM mark C2. With `markEn`=1 in MFM, byte 0xC2 has the clock cell in front of data bit 3 forced to 0. This gives 0x5224, where 0x52A4 would be the plain encoding.
- R8: Byte-taken timing. `byteTaken` is 1 for exactly the clock in which the last (16th) cell of a byte is on `wrData`. If `byteValid` is 1 in that clock, the byte on the inputs is accepted, and its first cell follows in the next clock with no gap.
- R9: Idle. When no byte is being sent, `wrData` is 0. A `byteValid` seen while idle is accepted at the next clock edge. Its first cell appears in the clock after that edge.
- R10: Inputs ignored mid-byte. While a byte is being sent, changes on `byteIn`, `mfmMode`, `markEn` and `byteValid` are ignored, except in the byte-taken clock.
- R11: No mark without markEn. A byte with `markEn`=0, or one whose value is not a mark value for the current mode, gets the plain clocking of that mode. For example, FM 0xFE unmarked gives 0xFFFE, and FM 0xC2 marked gives 0xFAAE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock; one encoded cell per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| byteIn | input | 8 | Byte to encode |
| mfmMode | input | 1 | 1 = MFM encoding, 0 = FM encoding |
| markEn | input | 1 | 1 = apply address-mark clocking to mark byte values |
| byteValid | input | 1 | A byte is presented on the inputs |
| wrData | output | 1 | Serial encoded cell stream |
| byteTaken | output | 1 | High while the last cell of a byte is sent; inputs are accepted in this cycle |

## Verification
Two things fall in the same clock: the final shift of the current byte and the load of the next one. In MFM, that next byte's first clock cell depends on the outgoing byte's bit 0. The stimulus table streams all its bytes back to back with `byteValid` held high. It chains modes and prior bits so that every load happens in a byte-taken cycle and inherits a known previous bit. Each received 16-cell word is compared with a hand-derived value, and the byte-taken pulse must appear only in cell 16. Directed cases then repeat the inheritance across an idle gap and after a reset, and they inject input noise in the middle of a byte.

// File: rtl/amser_pkg.sv
package amser_pkg;
  localparam int BYTE_W = 8;
  localparam int CELL_W = 2 * BYTE_W;
  localparam int CNT_W  = $clog2(CELL_W);

  typedef enum logic [2:0] {
    MK_PLAIN,
    MK_FM_ADDR,
    MK_FM_INDEX,
    MK_MFM_HOLE_A,
    MK_MFM_HOLE_B
  } markKind_e;

  typedef struct packed {
    logic load;    // capture the presented byte this cycle
    logic active;  // a byte is on the line
  } ctrlStrobes_t;
endpackage

// File: rtl/amserEncoder.sv
module amserEncoder
  import amser_pkg::*;
#(
  parameter logic [BYTE_W-1:0] FM_PLAIN_CLK = 8'hFF,
  parameter logic [BYTE_W-1:0] FM_ADDR_CLK  = 8'hC7,
  parameter logic [BYTE_W-1:0] FM_INDEX_CLK = 8'hD7,
  parameter logic [BYTE_W-1:0] MFM_MARK_A   = 8'hA1,
  parameter logic [BYTE_W-1:0] MFM_MARK_B   = 8'hC2,
  parameter int                HOLE_A_BIT   = 2,
  parameter int                HOLE_B_BIT   = 3
) (
  input  logic [BYTE_W-1:0] byteIn,
  input  logic              mfmMode,
  input  logic              markEn,
  input  logic              prevBit,
  output logic [CELL_W-1:0] cells
);
  markKind_e                kind;
  logic [BYTE_W-1:0]        clkBits;
  logic [BYTE_W:0]          withPrev;

  // Decide which clocking rule applies to this byte
  always_comb begin
    kind = MK_PLAIN;
    if (markEn) begin
      if (!mfmMode) begin
        if (byteIn == 8'hFC)
          kind = MK_FM_INDEX;
        else if ((byteIn >= 8'hF8 && byteIn <= 8'hFB) || byteIn == 8'hFE)
          kind = MK_FM_ADDR;
      end else begin
        if (byteIn == MFM_MARK_A)
          kind = MK_MFM_HOLE_A;
        else if (byteIn == MFM_MARK_B)
          kind = MK_MFM_HOLE_B;
      end
    end
  end

  assign withPrev = {prevBit, byteIn};

  always_comb begin
    if (!mfmMode) begin
      case (kind)
        MK_FM_ADDR:  clkBits = FM_ADDR_CLK;
        MK_FM_INDEX: clkBits = FM_INDEX_CLK;
        default:     clkBits = FM_PLAIN_CLK;
      endcase
    end else begin
      for (int i = 0; i < BYTE_W; i++) begin
        clkBits[i] = ~withPrev[i+1] & ~withPrev[i];
        if (kind == MK_MFM_HOLE_A && i == HOLE_A_BIT) clkBits[i] = 1'b0;
        if (kind == MK_MFM_HOLE_B && i == HOLE_B_BIT) clkBits[i] = 1'b0;
      end
    end
  end

  // Interleave: clock cell sits above its data cell, MSB pair at the top
  genvar g;
  generate
    for (g = 0; g < BYTE_W; g++) begin : gPair
      assign cells[2*g+1] = clkBits[g];
      assign cells[2*g]   = byteIn[g];
    end
  endgenerate
endmodule

// File: rtl/amserCtrl.sv
module amserCtrl
  import amser_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             byteValid,
  output ctrlStrobes_t     strb,
  output logic             lastCell,
  output logic [CNT_W-1:0] cellCnt
);
  logic busyQ;
  logic [CNT_W-1:0] cntQ;

  assign lastCell    = busyQ && (cntQ == CNT_W'(CELL_W - 1));
  assign strb.load   = byteValid && (!busyQ || lastCell);
  assign strb.active = busyQ;
  assign cellCnt     = cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      cntQ  <= '0;
    end else if (strb.load) begin
      busyQ <= 1'b1;
      cntQ  <= '0;
    end else if (lastCell) begin
      busyQ <= 1'b0;
      cntQ  <= '0;
    end else if (busyQ) begin
      cntQ  <= cntQ + 1'b1;
    end
  end
endmodule

// File: rtl/amserDatapath.sv
module amserDatapath
  import amser_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [BYTE_W-1:0] byteIn,
  input  logic              mfmMode,
  input  logic              markEn,
  output logic              wrData,
  output logic              curMfm
);
  logic [CELL_W-1:0] shiftQ;
  logic [CELL_W-1:0] cellsNext;
  logic              lastBitQ;
  logic              mfmQ;

  amserEncoder u_enc (
    .byteIn (byteIn),
    .mfmMode(mfmMode),
    .markEn (markEn),
    .prevBit(lastBitQ),
    .cells  (cellsNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ   <= '0;
      lastBitQ <= 1'b0;
      mfmQ     <= 1'b0;
    end else if (strb.load) begin
      shiftQ   <= cellsNext;
      lastBitQ <= byteIn[0];
      mfmQ     <= mfmMode;
    end else if (strb.active) begin
      shiftQ   <= {shiftQ[CELL_W-2:0], 1'b0};
    end
  end

  assign wrData = strb.active & shiftQ[CELL_W-1];
  assign curMfm = mfmQ;
endmodule

// File: rtl/amSerializer.sv
module amSerializer
  import amser_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] byteIn,
  input  logic              mfmMode,
  input  logic              markEn,
  input  logic              byteValid,
  output logic              wrData,
  output logic              byteTaken
);
  ctrlStrobes_t     strb;
  logic [CNT_W-1:0] cellCnt;
  logic             busy;
  logic             curMfm;

  amserCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .byteValid(byteValid),
    .strb     (strb),
    .lastCell (byteTaken),
    .cellCnt  (cellCnt)
  );

  amserDatapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .byteIn (byteIn),
    .mfmMode(mfmMode),
    .markEn (markEn),
    .wrData (wrData),
    .curMfm (curMfm)
  );

  assign busy = strb.active;
endmodule

// File: rtl/amserChecker.sv
module amserChecker
  import amser_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             byteValid,
  input logic             wrData,
  input logic             byteTaken,
  input logic             busy,
  input logic [CNT_W-1:0] cellCnt,
  input logic             curMfm
);
  a_r8_taken_single: assert property (@(posedge clk) disable iff (!rstN)
    byteTaken |=> !byteTaken);

  a_r8_back_to_back: assert property (@(posedge clk) disable iff (!rstN)
    (byteTaken && byteValid) |=> (busy && cellCnt == '0));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!wrData && !byteTaken));

  a_r9_idle_accept: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && byteValid) |=> (busy && cellCnt == '0));

  a_r10_run_on: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !byteTaken) |=> (busy && cellCnt == CNT_W'($past(cellCnt) + 1'b1)));

  a_r5_no_adjacent_ones: assert property (@(posedge clk) disable iff (!rstN)
    (busy && curMfm && $past(busy) && $past(wrData)) |-> !wrData);
endmodule

bind amSerializer amserChecker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .byteValid(byteValid),
  .wrData   (wrData),
  .byteTaken(byteTaken),
  .busy     (busy),
  .cellCnt  (cellCnt),
  .curMfm   (curMfm)
);

// File: tb/amSerializer_bench.sv
module amSerializer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;
  // {mfm, markEn, byte, expected 16-cell word}, streamed back to back
  localparam logic [25:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 8'h00, 16'hAAAA},
    {1'b0, 1'b1, 8'hFE, 16'hF57E},
    {1'b0, 1'b1, 8'hFC, 16'hF77A},
    {1'b0, 1'b0, 8'hFE, 16'hFFFE},
    {1'b0, 1'b1, 8'hF8, 16'hF56A},
    {1'b1, 1'b1, 8'hA1, 16'h4489},
    {1'b1, 1'b1, 8'hA1, 16'h4489},
    {1'b1, 1'b0, 8'hA1, 16'h44A9},
    {1'b1, 1'b1, 8'hC2, 16'h5224},
    {1'b1, 1'b0, 8'hC2, 16'h52A4},
    {1'b1, 1'b0, 8'h00, 16'hAAAA},
    {1'b1, 1'b0, 8'hFF, 16'h5555},
    {1'b1, 1'b0, 8'h00, 16'h2AAA},
    {1'b1, 1'b1, 8'h00, 16'hAAAA},
    {1'b0, 1'b1, 8'hC2, 16'hFAAE}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] byteIn = '0;
  logic       mfmMode = 1'b0;
  logic       markEn = 1'b0;
  logic       byteValid = 1'b0;
  logic       wrData;
  logic       byteTaken;

  int checks = 0;
  int errors = 0;

  // inputs applied in the byte-taken cycle of the byte being captured
  logic       nValid, nMfm, nMark;
  logic [7:0] nByte;
  bit         noiseOn = 0;

  amSerializer u_amSerializer (
    .clk(clk), .rstN(rstN), .byteIn(byteIn), .mfmMode(mfmMode),
    .markEn(markEn), .byteValid(byteValid), .wrData(wrData), .byteTaken(byteTaken)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tagOf(input int i);
    case (i)
      0: return "R2";   1: return "R3";   2: return "R4";
      3: return "R11";  4: return "R3";   5: return "R6";
      6: return "R6";   7: return "R5";   8: return "R7";
      9: return "R5";   10: return "R5";  11: return "R5";
      12: return "R5";  13: return "R11"; default: return "R11";
    endcase
  endfunction

  task automatic drive(input logic v, input logic m, input logic k, input logic [7:0] b);
    byteValid = v; mfmMode = m; markEn = k; byteIn = b;
  endtask

  task automatic setNext(input logic v, input logic m, input logic k, input logic [7:0] b);
    nValid = v; nMfm = m; nMark = k; nByte = b;
  endtask

  // Call right after presenting a byte at a falling edge
  task automatic captureByte(output logic [15:0] got, output bit takenOk);
    got = '0;
    takenOk = 1;
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      got = {got[14:0], wrData};
      if (byteTaken !== logic'(c == 15)) takenOk = 0;
      if (noiseOn && c == 5) begin
        byteIn = ~byteIn; mfmMode = ~mfmMode; markEn = ~markEn;
      end
      if (noiseOn && c == 8) byteValid = 1'b0;
      if (noiseOn && c == 11) byteValid = 1'b1;
      if (c == 15) drive(nValid, nMfm, nMark, nByte);
    end
  endtask

  task automatic idleCheck(input int n, input string req);
    bit ok = 1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (wrData !== 1'b0 || byteTaken !== 1'b0) ok = 0;
    end
    check(ok, req, {30'd0, wrData, byteTaken}, 32'd0);
  endtask

  initial begin
    logic [15:0] got;
    bit          tk;
    bit          tkAll;

    // R1: outputs quiet during and after reset
    repeat (3) @(negedge clk);
    check(wrData === 1'b0 && byteTaken === 1'b0, "R1 during reset", {wrData, byteTaken}, 0);
    rstN = 1'b1;
    idleCheck(3, "R1 after reset");

    // Table: back-to-back stream (R8 and R9 on the first load)
    tkAll = 1;
    drive(1'b1, VEC[0][25], VEC[0][24], VEC[0][23:16]);
    for (int i = 0; i < NVEC; i++) begin
      if (i < NVEC - 1)
        setNext(1'b1, VEC[i+1][25], VEC[i+1][24], VEC[i+1][23:16]);
      else
        setNext(1'b0, 1'b0, 1'b0, 8'h00);
      captureByte(got, tk);
      if (!tk) tkAll = 0;
      check(got === VEC[i][15:0], tagOf(i), {16'd0, got}, {16'd0, VEC[i][15:0]});
    end
    check(tkAll, "R8 taken only on last cell", {31'd0, tkAll}, 1);

    // R9: idle line after the stream
    idleCheck(4, "R9 idle quiet");

    // R5: previous bit survives an idle gap
    drive(1'b1, 1'b1, 1'b0, 8'hFF);
    setNext(1'b0, 1'b0, 1'b0, 8'h00);
    captureByte(got, tk);
    check(got === 16'h5555, "R5 MFM FF", {16'd0, got}, 32'h5555);
    idleCheck(3, "R9 gap quiet");
    drive(1'b1, 1'b1, 1'b0, 8'h00);
    captureByte(got, tk);
    check(got === 16'h2AAA, "R5 prev bit across idle", {16'd0, got}, 32'h2AAA);
    check(tk, "R8 taken single byte", {31'd0, tk}, 1);

    // R10: input noise in mid-byte has no effect
    noiseOn = 1;
    drive(1'b1, 1'b1, 1'b1, 8'hA1);
    captureByte(got, tk);
    noiseOn = 0;
    check(got === 16'h4489, "R10 noise ignored", {16'd0, got}, 32'h4489);
    idleCheck(2, "R10 line idle after noisy byte");

    // R1: reset clears the remembered bit
    drive(1'b1, 1'b1, 1'b0, 8'hFF);
    captureByte(got, tk);
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    drive(1'b1, 1'b1, 1'b0, 8'h00);
    captureByte(got, tk);
    check(got === 16'hAAAA, "R1 prev bit cleared", {16'd0, got}, 32'hAAAA);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule